// File: doc/BRIEF.md
# Dual Shadow Register Checkpoint Engine

This block saves and restores a processor's architectural register file so that execution can be rolled back after a fault is detected. It keeps two shadow copies of the register file, one for each of the two live speculative epochs. A checkpoint overwrites the slot of the older epoch, which is committed and discarded, and that slot then holds the newest epoch. A rollback reloads the main file from whichever slot holds the older of the two checkpoints, so at least one whole epoch can always be undone.

The engine drives the main file's read address, and its write port while it restores. Registers move at one per cycle, because the main file has a single write port. Registers not flagged in the valid mask are skipped at no cycle cost. The engine holds the pipeline stalled for the whole operation. It then gives a one-cycle reinitialize pulse, together with a done flag that names the operation just finished.

Top module: `regsnap_engine`

## Requirements
- R1: After reset, `stall`, `reinit`, `ckpt_done`, `rb_done` and `main_wr_en` are all 0. Both shadow slots hold an all-zero snapshot that covers every register.
- R2: A request accepted in idle raises `stall` on the next cycle. `stall` stays high for max(k,1)+1 cycles, where k is the number of registers moved. `reinit` is high only in the last of those cycles, together with exactly one of `ckpt_done` (checkpoint) or `rb_done` (rollback).
- R3: A checkpoint reads the registers whose bit is set in `reg_valid` (bit i = register i), one per cycle in ascending index order, into the slot of the older epoch. It never writes the main file.
- R4: A rollback writes the main file one register per cycle in ascending index order. It writes only the registers that were valid when the restored checkpoint was taken, with the values they held then. Other registers keep their contents.
- R5: Slots alternate. After checkpoints A then B, a rollback restores A's contents.
- R6: A rollback before any checkpoint writes zero to every register.
- R7: After exactly one checkpoint since reset, a rollback still restores the all-zero reset snapshot.
- R8: If `ckpt_req` and `rb_req` are both high in the same idle cycle, only the rollback is performed.
- R9: Requests that arrive while `stall` is high are ignored: no further operation starts, and the saved checkpoints are unchanged.
- R10: After a rollback, both slots hold the restored state, so an immediate second rollback restores the same values.
- R11: A checkpoint with an empty valid mask takes one work cycle plus the reinitialize cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ckpt_req | input | 1 | Take a checkpoint (sampled in idle) |
| rb_req | input | 1 | Roll back to the older checkpoint (sampled in idle, wins over ckpt_req) |
| reg_valid | input | NREG | Valid-register mask captured when a checkpoint is accepted |
| main_rd_addr | output | log2(NREG) | Main file read address (combinational read) |
| main_rd_data | input | W | Main file read data |
| main_wr_en | output | 1 | Main file write enable during rollback |
| main_wr_addr | output | log2(NREG) | Main file write address |
| main_wr_data | output | W | Main file write data |
| stall | output | 1 | Pipeline stall while the engine is busy |
| reinit | output | 1 | One-cycle pipeline reinitialize pulse |
| ckpt_done | output | 1 | Checkpoint finished (with reinit) |
| rb_done | output | 1 | Rollback finished (with reinit) |

## Verification
The checker watches the handshake shape on every cycle. `reinit` lasts exactly one cycle, sits inside the stall and carries a single done flag. `stall` only falls after `reinit`. The main file is written only during busy work cycles, and successive restore writes climb in register index. The actual data movement can only be shown by the bench's scenarios. These cover which slot is the older one across alternating checkpoints, the reset snapshot, masks that skip registers, the request priority, requests ignored while busy, and back-to-back rollbacks. The bench compares every restore write and the final file contents against its own model of the two slots.

// File: rtl/regsnap_pkg.sv
package regsnap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAVE   = 2'd1,
        ST_LOAD   = 2'd2,
        ST_REINIT = 2'd3
    } snap_state_e;

    // Context of the operation in flight
    typedef struct packed {
        logic is_load;   // 1: rollback, 0: checkpoint
    } snap_op_t;

endpackage

// File: rtl/regsnap_pick.sv
// Lowest-index set bit of a request vector.
module regsnap_pick #(
    parameter int N  = 16,
    localparam int AW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [AW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = AW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/regsnap_bank.sv
// One shadow copy of the register file: one write port, one combinational read port.
module regsnap_bank #(
    parameter int NREG = 16,
    parameter int W    = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/regsnap_engine.sv
module regsnap_engine
    import regsnap_pkg::*;
#(
    parameter int NREG = 16,
    parameter int W    = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ckpt_req,
    input  logic            rb_req,
    input  logic [NREG-1:0] reg_valid,
    output logic [AW-1:0]   main_rd_addr,
    input  logic [W-1:0]    main_rd_data,
    output logic            main_wr_en,
    output logic [AW-1:0]   main_wr_addr,
    output logic [W-1:0]    main_wr_data,
    output logic            stall,
    output logic            reinit,
    output logic            ckpt_done,
    output logic            rb_done
);
    snap_state_e     state_q;
    snap_op_t        op_q;
    logic            older_q;          // slot holding the older checkpoint
    logic [NREG-1:0] pend_q;           // registers still to move
    logic [NREG-1:0] pend_next;
    logic [NREG-1:0] smask_q [2];      // valid mask captured with each slot
    logic [AW-1:0]   idx;
    logic            any;
    logic            work;
    logic [W-1:0]    bank_rd [2];

    regsnap_pick #(.N(NREG)) u_pick (
        .req (pend_q),
        .idx (idx),
        .any (any)
    );

    always_comb begin
        pend_next      = pend_q;
        pend_next[idx] = 1'b0;
    end

    assign work = any && (state_q == ST_SAVE || state_q == ST_LOAD);

    // Two shadow slots; a checkpoint fills the older slot, a rollback
    // copies the older slot into the other one alongside the main file.
    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic         we;
        logic [W-1:0] wdata;
        assign we = work && ((state_q == ST_SAVE && older_q == 1'(g)) ||
                             (state_q == ST_LOAD && older_q != 1'(g)));
        assign wdata = (state_q == ST_SAVE) ? main_rd_data : bank_rd[older_q];
        regsnap_bank #(.NREG(NREG), .W(W)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (we),
            .waddr (idx),
            .wdata (wdata),
            .raddr (idx),
            .rdata (bank_rd[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            op_q       <= '0;
            older_q    <= 1'b0;
            pend_q     <= '0;
            smask_q[0] <= '1;
            smask_q[1] <= '1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (rb_req) begin
                        state_q           <= ST_LOAD;
                        op_q.is_load      <= 1'b1;
                        pend_q            <= smask_q[older_q];
                        smask_q[~older_q] <= smask_q[older_q];
                    end else if (ckpt_req) begin
                        state_q          <= ST_SAVE;
                        op_q.is_load     <= 1'b0;
                        pend_q           <= reg_valid;
                        smask_q[older_q] <= reg_valid;
                    end
                end
                ST_SAVE: begin
                    pend_q <= pend_next;
                    if (pend_next == '0) begin
                        state_q <= ST_REINIT;
                        older_q <= ~older_q;
                    end
                end
                ST_LOAD: begin
                    pend_q <= pend_next;
                    if (pend_next == '0) state_q <= ST_REINIT;
                end
                ST_REINIT: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    assign main_rd_addr = idx;
    assign main_wr_en   = work && (state_q == ST_LOAD);
    assign main_wr_addr = idx;
    assign main_wr_data = bank_rd[older_q];
    assign stall        = (state_q != ST_IDLE);
    assign reinit       = (state_q == ST_REINIT);
    assign ckpt_done    = reinit && !op_q.is_load;
    assign rb_done      = reinit && op_q.is_load;
endmodule

// File: rtl/regsnap_engine_chk.sv
module regsnap_engine_chk #(
    parameter int NREG = 16,
    localparam int AW  = $clog2(NREG)
) (
    input logic          clk,
    input logic          rst,
    input logic          stall,
    input logic          reinit,
    input logic          ckpt_done,
    input logic          rb_done,
    input logic          main_wr_en,
    input logic [AW-1:0] main_wr_addr
);
    // R2
    reinit_in_stall_chk: assert property (@(posedge clk) disable iff (rst)
        reinit |-> stall);

    // R2
    reinit_single_chk: assert property (@(posedge clk) disable iff (rst)
        reinit |=> !reinit);

    // R2
    done_with_reinit_chk: assert property (@(posedge clk) disable iff (rst)
        (ckpt_done || rb_done) |-> (reinit && !(ckpt_done && rb_done)));

    // R2
    release_after_reinit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(stall) |-> $past(reinit));

    // R3
    write_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        main_wr_en |-> (stall && !reinit));

    // R4
    ascending_write_chk: assert property (@(posedge clk) disable iff (rst)
        (main_wr_en && $past(main_wr_en)) |-> (main_wr_addr > $past(main_wr_addr)));
endmodule

bind regsnap_engine regsnap_engine_chk #(.NREG(NREG)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .stall        (stall),
    .reinit       (reinit),
    .ckpt_done    (ckpt_done),
    .rb_done      (rb_done),
    .main_wr_en   (main_wr_en),
    .main_wr_addr (main_wr_addr)
);

// File: tb/test_regsnap_engine.sv
`timescale 1ns/1ps
module test_regsnap_engine;
    localparam int NREG = 16;
    localparam int W    = 16;
    localparam int AW   = $clog2(NREG);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ckpt_req = 1'b0;
    logic            rb_req = 1'b0;
    logic [NREG-1:0] reg_valid = '0;
    logic [AW-1:0]   main_rd_addr;
    logic [W-1:0]    main_rd_data;
    logic            main_wr_en;
    logic [AW-1:0]   main_wr_addr;
    logic [W-1:0]    main_wr_data;
    logic            stall, reinit, ckpt_done, rb_done;

    always #2 clk = ~clk;   // 250 MHz

    regsnap_engine #(.NREG(NREG), .W(W)) i_regsnap_engine (
        .clk(clk), .rst(rst), .ckpt_req(ckpt_req), .rb_req(rb_req),
        .reg_valid(reg_valid), .main_rd_addr(main_rd_addr),
        .main_rd_data(main_rd_data), .main_wr_en(main_wr_en),
        .main_wr_addr(main_wr_addr), .main_wr_data(main_wr_data),
        .stall(stall), .reinit(reinit), .ckpt_done(ckpt_done), .rb_done(rb_done)
    );

    // Main register file model
    logic [W-1:0] mem [NREG];
    always @(posedge clk) if (main_wr_en) mem[main_wr_addr] <= main_wr_data;
    assign main_rd_data = mem[main_rd_addr];

    // Reference of the two saved checkpoints
    logic [W-1:0]    refval [2][NREG];
    logic [NREG-1:0] refmask [2];
    logic            refold;

    int nchk = 0;
    int nfail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // op: 0 checkpoint, 1 rollback, 2 both requests; seed 0 = no refill
    localparam logic [25:0] OPS [10] = '{
        {2'd1, 16'h0000, 8'h11},   // R6 rollback before any checkpoint
        {2'd0, 16'hFFFF, 8'h22},
        {2'd0, 16'h00F0, 8'h33},
        {2'd1, 16'h0000, 8'h44},   // R5 restores first of the pair
        {2'd0, 16'hA5A5, 8'h55},
        {2'd0, 16'h0000, 8'h66},   // R11 empty mask
        {2'd2, 16'hFFFF, 8'h77},   // R8 both requests
        {2'd1, 16'h0000, 8'h88},   // R10 second rollback
        {2'd0, 16'h8001, 8'h99},
        {2'd1, 16'h0000, 8'hAA}
    };

    task automatic fill(input logic [7:0] seed);
        for (int i = 0; i < NREG; i++) mem[i] = W'(int'(seed) * 257 + i * 3 + 1);
    endtask

    task automatic do_reset();
        rst = 1'b1; ckpt_req = 1'b0; rb_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int s = 0; s < 2; s++) begin
            refmask[s] = '1;
            for (int i = 0; i < NREG; i++) refval[s][i] = '0;
        end
        refold = 1'b0;
        @(negedge clk);
        chk(!stall && !reinit && !ckpt_done && !rb_done && !main_wr_en, "R1",
            "idle outputs after reset",
            {stall, reinit, ckpt_done, rb_done, main_wr_en}, 0);
    endtask

    task automatic run_op(input logic [1:0] op, input logic [NREG-1:0] mask,
                          input logic [7:0] seed, input bit inject);
        logic [W-1:0]    exp_main [NREG];
        logic [NREG-1:0] emask, rem;
        logic [W-1:0]    src [NREG];
        bit              is_rb;
        int              exp_cyc, cyc, nwr, pop, lo;
        bit              saw_done;
        string           rq;
        if (seed != 0) fill(seed);
        is_rb = (op != 2'd0);
        rq    = is_rb ? "R4" : "R3";
        for (int i = 0; i < NREG; i++) begin
            src[i]      = refval[refold][i];
            exp_main[i] = mem[i];
        end
        if (is_rb) begin
            emask = refmask[refold];
            for (int i = 0; i < NREG; i++) if (emask[i]) exp_main[i] = src[i];
        end else begin
            emask = mask;
        end
        pop     = $countones(emask);
        exp_cyc = ((pop > 0) ? pop : 1) + 1;
        rem     = is_rb ? emask : '0;
        @(negedge clk);
        reg_valid = mask;
        ckpt_req  = (op != 2'd1);
        rb_req    = (op != 2'd0);
        @(negedge clk);
        ckpt_req = 1'b0; rb_req = 1'b0;
        chk(stall, "R2", "stall one cycle after request", stall, 1);
        cyc = 0; nwr = 0; saw_done = 0;
        while (stall && cyc < 200) begin
            if (main_wr_en) begin
                lo = 0;
                for (int i = NREG - 1; i >= 0; i--) if (rem[i]) lo = i;
                chk(rem != '0 && main_wr_addr == AW'(lo), rq, "restore write address",
                    main_wr_addr, lo);
                chk(main_wr_data == src[lo], rq, "restore write data",
                    main_wr_data, src[lo]);
                rem[lo] = 1'b0;
                nwr++;
            end
            if (reinit) begin
                saw_done = 1;
                chk(cyc == exp_cyc - 1, "R2", "reinit position", cyc, exp_cyc - 1);
                chk(rb_done == is_rb && ckpt_done == !is_rb, "R2", "done flag kind",
                    {ckpt_done, rb_done}, {!is_rb, is_rb});
            end
            if (inject) ckpt_req = (cyc == 2);   // R9 request while busy
            cyc++;
            @(negedge clk);
        end
        ckpt_req = 1'b0;
        chk(cyc == exp_cyc, (pop == 0 && !is_rb) ? "R11" : "R2", "stall length",
            cyc, exp_cyc);
        chk(saw_done, "R2", "reinit seen", saw_done, 1);
        chk(nwr == (is_rb ? pop : 0), rq, "number of main writes", nwr, is_rb ? pop : 0);
        for (int i = 0; i < NREG; i++)
            chk(mem[i] == exp_main[i], rq, $sformatf("main reg %0d after op", i),
                mem[i], exp_main[i]);
        if (inject) begin
            @(negedge clk);
            chk(!stall, "R9", "no operation started by busy request", stall, 0);
        end
        // reference update
        if (is_rb) begin
            refmask[~refold] = refmask[refold];
            for (int i = 0; i < NREG; i++) refval[~refold][i] = refval[refold][i];
        end else begin
            refmask[refold] = mask;
            for (int i = 0; i < NREG; i++) refval[refold][i] = exp_main[i];
            refold = ~refold;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nfail++; nchk++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) mem[i] = '0;
        do_reset();                                   // R1
        for (int t = 0; t < 10; t++)
            run_op(OPS[t][25:24], OPS[t][23:8], OPS[t][7:0], 1'b0);
        // R7: one checkpoint after reset, rollback returns zeros
        do_reset();
        run_op(2'd0, 16'hFFFF, 8'hD1, 1'b0);
        fill(8'hD2);
        run_op(2'd1, 16'h0000, 8'h00, 1'b0);
        for (int i = 0; i < NREG; i++)
            chk(mem[i] == '0, "R7", $sformatf("reg %0d zero after rollback", i), mem[i], 0);
        // R9: checkpoint during rollback is ignored, saved state unchanged
        run_op(2'd0, 16'h00FF, 8'hBB, 1'b0);
        run_op(2'd0, 16'h0F0F, 8'hBC, 1'b0);
        run_op(2'd1, 16'h0000, 8'hBD, 1'b1);
        run_op(2'd1, 16'h0000, 8'hCC, 1'b0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule